// File: doc/BRIEF.md
# Device-State Enable Sequencer

This block turns a request of the form (device id, enable or disable) into a read-modify-write of a control register, then waits for the device to confirm its new state. Each device id falls into a contiguous id range. Each range is described by an entry in a small control table, which fixes the register offset, where the range's first field sits, how many bits each device gets, and which codes mean "on" and "off". A second table, built the same way, describes status fields. When a device has a status field, the sequencer reads it repeatedly until it shows the requested state, or until a programmable poll budget runs out.

Requests arrive on a valid/ready handshake, and only one request is in flight at a time. All register traffic goes through a single master port that holds each access until it is acknowledged. Every accepted request ends in a one-cycle `done` pulse together with a result code. Both tables are written through a configuration port and are empty after reset.

Top module: `devstate_seq`

## Requirements
- R1: A request id maps to the lowest-index control entry with a nonzero count for which start ≤ id < start + count. All entries are empty after reset. The status table is looked up the same way.
- R2: A device's field sits at bit start bit + bits-per-device × (id − start id). It is bits-per-device wide, and the code written into it is cut to that width.
- R3: An accepted enable or disable first reads the control register at the entry's offset. It then writes the value back once, with only the device's field replaced by the enable code or the disable code. All other bits keep their values.
- R4: When a control entry's disable code is all ones (8'hFF), that range is enable-only. A disable request for such a device completes with result 3 (ignored) and makes no bus access.
- R5: A request completes with result 1 (bad request) and makes no bus access when its id has no control entry, or when its state is neither 2'b01 (enable) nor 2'b10 (disable).
- R6: If the id has a status entry, the sequencer reads the status register after the write, and keeps reading it until the field equals that entry's enable code (for an enable) or disable code (for a disable). It then completes with result 0.
- R7: If the id has no status entry, the request completes with result 0 right after the write is acknowledged.
- R8: Mismatching status reads are counted. The mismatch that brings the count to max(pollLimit, 1) ends the request with result 2 (timeout).
- R9: reqReady is high only when the sequencer is idle, and falls in the cycle after a request is accepted. Each accepted request produces exactly one one-cycle `done` pulse, with errCode valid in that cycle. reqReady is high again in the cycle after `done`.
- R10: While busReq is high and busAck is low, busReq stays high, and busAddr, busWr and busWdata stay unchanged.
- R11: Straight after reset, reqReady is 1 and both done and busReq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqId | input | ID_W | Device id |
| reqState | input | 2 | 01 enable, 10 disable, others invalid |
| reqReady | output | 1 | Sequencer idle, request taken at this edge |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 2 | 0 ok, 1 bad request, 2 timeout, 3 ignored |
| pollLimit | input | TMO_W | Mismatching status reads allowed |
| cfgWe | input | 1 | Table entry write strobe |
| cfgTable | input | 1 | 0 control table, 1 status table |
| cfgIdx | input | IDX_W | Entry index |
| cfgStartId | input | ID_W | First id of range |
| cfgCount | input | ID_W+1 | Ids in range, 0 means empty |
| cfgOffset | input | ADDR_W | Register offset |
| cfgEnCode | input | CODE_W | Enable code |
| cfgDisCode | input | CODE_W | Disable code (all ones marks enable-only) |
| cfgStartBit | input | SB_W | Bit of the range's first field |
| cfgBits | input | NB_W | Bits per device |
| busReq | output | 1 | Bus access request |
| busWr | output | 1 | 1 write, 0 read |
| busAddr | output | ADDR_W | Register offset |
| busWdata | output | DATA_W | Write data |
| busAck | input | 1 | Access complete at this edge |
| busRdata | input | DATA_W | Read data, valid with busAck |

## Verification
The bench builds the block with its default parameters: 32 ids, 8 entries per table, 32-bit registers, 8-bit codes and a 16-bit poll budget. At this size every id can be swept in both directions. The control layout mixes 1-, 2-, 3- and 4-bit fields, two ranges that share one register, an enable-only range, a shadowed overlapping entry and a block of unmapped ids. For each request, a model in the bench works out the expected register words, bus operation counts and status read counts. The status registers answer only after a chosen number of reads, so the same request can be driven to a match or to a timeout, including at the budget boundary and with a budget of zero.

// File: rtl/devstate_pkg.sv
package devstate_pkg;

  typedef enum logic [1:0] {
    ERR_OK      = 2'd0,
    ERR_BADREQ  = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_IGNORED = 2'd3
  } seqErr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_RDCTL,
    ST_WRCTL,
    ST_POLL,
    ST_FIN
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic latchReq;
    logic capRead;
    logic pollClr;
    logic pollInc;
    logic selStat;
  } seqStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic ctlHit;
    logic statHit;
    logic enOnly;
    logic stateBad;
    logic wantOn;
    logic statMatch;
    logic pollLast;
  } seqFlags_t;

endpackage

// File: rtl/devstate_rangetab.sv
module devstate_rangetab #(
  parameter int NRNG   = 8,
  parameter int ID_W   = 5,
  parameter int ADDR_W = 8,
  parameter int CODE_W = 8,
  parameter int SB_W   = 5,
  parameter int NB_W   = 4,
  localparam int IDX_W = $clog2(NRNG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ID_W-1:0]   wrStart,
  input  logic [ID_W:0]     wrCount,
  input  logic [ADDR_W-1:0] wrOffset,
  input  logic [CODE_W-1:0] wrEn,
  input  logic [CODE_W-1:0] wrDis,
  input  logic [SB_W-1:0]   wrSb,
  input  logic [NB_W-1:0]   wrNb,
  input  logic [ID_W-1:0]   lookId,
  output logic              hit,
  output logic [ID_W-1:0]   base,
  output logic [ADDR_W-1:0] offset,
  output logic [CODE_W-1:0] enCode,
  output logic [CODE_W-1:0] disCode,
  output logic [SB_W-1:0]   startBit,
  output logic [NB_W-1:0]   bitsPer
);

  logic [ID_W-1:0]   startQ [NRNG];
  logic [ID_W:0]     countQ [NRNG];
  logic [ADDR_W-1:0] offQ   [NRNG];
  logic [CODE_W-1:0] enQ    [NRNG];
  logic [CODE_W-1:0] disQ   [NRNG];
  logic [SB_W-1:0]   sbQ    [NRNG];
  logic [NB_W-1:0]   nbQ    [NRNG];
  logic [NRNG-1:0]   match;
  logic [IDX_W-1:0]  sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NRNG; i++) begin
        startQ[i] <= '0;
        countQ[i] <= '0;
        offQ[i]   <= '0;
        enQ[i]    <= '0;
        disQ[i]   <= '0;
        sbQ[i]    <= '0;
        nbQ[i]    <= '0;
      end
    end else if (we) begin
      startQ[wrIdx] <= wrStart;
      countQ[wrIdx] <= wrCount;
      offQ[wrIdx]   <= wrOffset;
      enQ[wrIdx]    <= wrEn;
      disQ[wrIdx]   <= wrDis;
      sbQ[wrIdx]    <= wrSb;
      nbQ[wrIdx]    <= wrNb;
    end
  end

  for (genvar g = 0; g < NRNG; g++) begin : g_match
    logic [ID_W:0] rel;
    assign rel      = {1'b0, lookId} - {1'b0, startQ[g]};
    assign match[g] = (countQ[g] != '0) && (lookId >= startQ[g]) && (rel < countQ[g]);
  end

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NRNG - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign base     = startQ[sel];
  assign offset   = offQ[sel];
  assign enCode   = enQ[sel];
  assign disCode  = disQ[sel];
  assign startBit = sbQ[sel];
  assign bitsPer  = nbQ[sel];

endmodule

// File: rtl/devstate_dp.sv
module devstate_dp
  import devstate_pkg::*;
#(
  parameter int NRNG   = 8,
  parameter int ID_W   = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CODE_W = 8,
  parameter int NB_W   = 4,
  parameter int TMO_W  = 16,
  localparam int IDX_W = $clog2(NRNG),
  localparam int SB_W  = $clog2(DATA_W),
  localparam int SH_W  = SB_W + NB_W + ID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgTable,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ID_W-1:0]   cfgStartId,
  input  logic [ID_W:0]     cfgCount,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic [CODE_W-1:0] cfgEnCode,
  input  logic [CODE_W-1:0] cfgDisCode,
  input  logic [SB_W-1:0]   cfgStartBit,
  input  logic [NB_W-1:0]   cfgBits,
  input  logic [ID_W-1:0]   reqId,
  input  logic [1:0]        reqState,
  input  logic [TMO_W-1:0]  pollLimit,
  input  seqStrobe_t        stb,
  input  logic [DATA_W-1:0] busRdata,
  output seqFlags_t         flags,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata
);

  logic              cHit, sHit;
  logic [ID_W-1:0]   cBase, sBase;
  logic [ADDR_W-1:0] cOff, sOff;
  logic [CODE_W-1:0] cEn, cDis, sEn, sDis;
  logic [SB_W-1:0]   cSb, sSb;
  logic [NB_W-1:0]   cNb, sNb;

  devstate_rangetab #(.NRNG(NRNG), .ID_W(ID_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
                      .SB_W(SB_W), .NB_W(NB_W)) u_ctlTab (
    .clk(clk), .rstN(rstN), .we(cfgWe && !cfgTable), .wrIdx(cfgIdx),
    .wrStart(cfgStartId), .wrCount(cfgCount), .wrOffset(cfgOffset),
    .wrEn(cfgEnCode), .wrDis(cfgDisCode), .wrSb(cfgStartBit), .wrNb(cfgBits),
    .lookId(reqId), .hit(cHit), .base(cBase), .offset(cOff), .enCode(cEn),
    .disCode(cDis), .startBit(cSb), .bitsPer(cNb));

  devstate_rangetab #(.NRNG(NRNG), .ID_W(ID_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
                      .SB_W(SB_W), .NB_W(NB_W)) u_statTab (
    .clk(clk), .rstN(rstN), .we(cfgWe && cfgTable), .wrIdx(cfgIdx),
    .wrStart(cfgStartId), .wrCount(cfgCount), .wrOffset(cfgOffset),
    .wrEn(cfgEnCode), .wrDis(cfgDisCode), .wrSb(cfgStartBit), .wrNb(cfgBits),
    .lookId(reqId), .hit(sHit), .base(sBase), .offset(sOff), .enCode(sEn),
    .disCode(sDis), .startBit(sSb), .bitsPer(sNb));

  // latched request context
  logic [ID_W-1:0]   idQ;
  logic [1:0]        stQ;
  logic              cHitQ, sHitQ;
  logic [ID_W-1:0]   cBaseQ, sBaseQ;
  logic [ADDR_W-1:0] cOffQ, sOffQ;
  logic [CODE_W-1:0] cEnQ, cDisQ, sEnQ, sDisQ;
  logic [SB_W-1:0]   cSbQ, sSbQ;
  logic [NB_W-1:0]   cNbQ, sNbQ;
  logic [DATA_W-1:0] rdQ;
  logic [TMO_W-1:0]  pollCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idQ <= '0; stQ <= '0; cHitQ <= 1'b0; sHitQ <= 1'b0;
      cBaseQ <= '0; sBaseQ <= '0; cOffQ <= '0; sOffQ <= '0;
      cEnQ <= '0; cDisQ <= '0; sEnQ <= '0; sDisQ <= '0;
      cSbQ <= '0; sSbQ <= '0; cNbQ <= '0; sNbQ <= '0;
    end else if (stb.latchReq) begin
      idQ <= reqId; stQ <= reqState; cHitQ <= cHit; sHitQ <= sHit;
      cBaseQ <= cBase; sBaseQ <= sBase; cOffQ <= cOff; sOffQ <= sOff;
      cEnQ <= cEn; cDisQ <= cDis; sEnQ <= sEn; sDisQ <= sDis;
      cSbQ <= cSb; sSbQ <= sSb; cNbQ <= cNb; sNbQ <= sNb;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdQ <= '0;
    else if (stb.capRead) rdQ <= busRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pollCnt <= '0;
    else if (stb.pollClr) pollCnt <= TMO_W'(1);
    else if (stb.pollInc) pollCnt <= pollCnt + TMO_W'(1);
  end

  logic              wantOn;
  logic [SH_W-1:0]   cShift, sShift;
  logic [DATA_W-1:0] cOnes, sOnes, cMask, cVal, sField;
  logic [CODE_W-1:0] cCode, sCode;

  assign wantOn = (stQ == 2'b01);
  assign cShift = SH_W'(cSbQ) + SH_W'(cNbQ) * SH_W'(idQ - cBaseQ);
  assign sShift = SH_W'(sSbQ) + SH_W'(sNbQ) * SH_W'(idQ - sBaseQ);
  assign cOnes  = (DATA_W'(1) << cNbQ) - DATA_W'(1);
  assign sOnes  = (DATA_W'(1) << sNbQ) - DATA_W'(1);
  assign cMask  = cOnes << cShift;
  assign cCode  = wantOn ? cEnQ : cDisQ;
  assign sCode  = wantOn ? sEnQ : sDisQ;
  assign cVal   = (DATA_W'(cCode) & cOnes) << cShift;
  assign sField = (busRdata >> sShift) & sOnes;

  assign busWdata = (rdQ & ~cMask) | cVal;
  assign busAddr  = stb.selStat ? sOffQ : cOffQ;

  assign flags.ctlHit    = cHitQ;
  assign flags.statHit   = sHitQ;
  assign flags.enOnly    = (cDisQ == {CODE_W{1'b1}});
  assign flags.stateBad  = (stQ != 2'b01) && (stQ != 2'b10);
  assign flags.wantOn    = wantOn;
  assign flags.statMatch = (sField == DATA_W'(sCode));
  assign flags.pollLast  = (pollCnt >= pollLimit);

  // R8: poll counter never runs while idle-capture happens
  a_r8_cnt_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    stb.pollInc |-> pollCnt != '0);

endmodule

// File: rtl/devstate_ctrl.sv
module devstate_ctrl
  import devstate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       done,
  output seqErr_t    errQ,
  output logic       busReq,
  output logic       busWr,
  input  logic       busAck,
  input  seqFlags_t  flags,
  output seqStrobe_t stb
);

  seqState_t state, stateNext;
  seqErr_t   errNext;

  always_comb begin
    stateNext = state;
    errNext   = errQ;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_DECIDE;
      ST_DECIDE: begin
        if (flags.stateBad || !flags.ctlHit) begin
          stateNext = ST_FIN; errNext = ERR_BADREQ;
        end else if (!flags.wantOn && flags.enOnly) begin
          stateNext = ST_FIN; errNext = ERR_IGNORED;
        end else begin
          stateNext = ST_RDCTL;
        end
      end
      ST_RDCTL:  if (busAck) stateNext = ST_WRCTL;
      ST_WRCTL:  if (busAck) begin
        if (flags.statHit) stateNext = ST_POLL;
        else begin stateNext = ST_FIN; errNext = ERR_OK; end
      end
      ST_POLL:   if (busAck) begin
        if (flags.statMatch) begin stateNext = ST_FIN; errNext = ERR_OK; end
        else if (flags.pollLast) begin stateNext = ST_FIN; errNext = ERR_TIMEOUT; end
      end
      ST_FIN:    stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= ERR_OK;
    end else begin
      state <= stateNext;
      errQ  <= errNext;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = (state == ST_FIN);
  assign busReq   = (state == ST_RDCTL) || (state == ST_WRCTL) || (state == ST_POLL);
  assign busWr    = (state == ST_WRCTL);

  assign stb.latchReq = reqReady && reqValid;
  assign stb.capRead  = (state == ST_RDCTL) && busAck;
  assign stb.pollClr  = (state == ST_WRCTL) && busAck;
  assign stb.pollInc  = (state == ST_POLL) && busAck && !flags.statMatch && !flags.pollLast;
  assign stb.selStat  = (state == ST_POLL);

  a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && reqReady);
  a_r5_bad_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    done && errQ == ERR_BADREQ |-> $past(!busReq));
  a_r4_ignored_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    done && errQ == ERR_IGNORED |-> $past(!busReq));
  a_r6_ok_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    done && errQ == ERR_OK |-> $past(busReq && busAck));
  a_r8_timeout_after_read: assert property (@(posedge clk) disable iff (!rstN)
    done && errQ == ERR_TIMEOUT |-> $past(busReq && busAck && !busWr));

endmodule

// File: rtl/devstate_seq.sv
module devstate_seq
  import devstate_pkg::*;
#(
  parameter int NRNG   = 8,
  parameter int ID_W   = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CODE_W = 8,
  parameter int NB_W   = 4,
  parameter int TMO_W  = 16,
  localparam int IDX_W = $clog2(NRNG),
  localparam int SB_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqId,
  input  logic [1:0]        reqState,
  output logic              reqReady,
  output logic              done,
  output logic [1:0]        errCode,
  input  logic [TMO_W-1:0]  pollLimit,
  input  logic              cfgWe,
  input  logic              cfgTable,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ID_W-1:0]   cfgStartId,
  input  logic [ID_W:0]     cfgCount,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic [CODE_W-1:0] cfgEnCode,
  input  logic [CODE_W-1:0] cfgDisCode,
  input  logic [SB_W-1:0]   cfgStartBit,
  input  logic [NB_W-1:0]   cfgBits,
  output logic              busReq,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata
);

  seqStrobe_t stb;
  seqFlags_t  flags;
  seqErr_t    err;

  devstate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .done(done), .errQ(err), .busReq(busReq), .busWr(busWr),
    .busAck(busAck), .flags(flags), .stb(stb));

  devstate_dp #(.NRNG(NRNG), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .CODE_W(CODE_W), .NB_W(NB_W), .TMO_W(TMO_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgTable(cfgTable), .cfgIdx(cfgIdx),
    .cfgStartId(cfgStartId), .cfgCount(cfgCount), .cfgOffset(cfgOffset),
    .cfgEnCode(cfgEnCode), .cfgDisCode(cfgDisCode), .cfgStartBit(cfgStartBit),
    .cfgBits(cfgBits), .reqId(reqId), .reqState(reqState), .pollLimit(pollLimit),
    .stb(stb), .busRdata(busRdata), .flags(flags), .busAddr(busAddr),
    .busWdata(busWdata));

  assign errCode = err;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWr) && $stable(busWdata));

endmodule

// File: tb/devstate_seq_tb.sv
module devstate_seq_tb;

  localparam time CYC = 5ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [4:0]  reqId = '0;
  logic [1:0]  reqState = '0;
  logic        reqReady, done;
  logic [1:0]  errCode;
  logic [15:0] pollLimit = '0;
  logic        cfgWe = 1'b0, cfgTable = 1'b0;
  logic [2:0]  cfgIdx = '0;
  logic [4:0]  cfgStartId = '0;
  logic [5:0]  cfgCount = '0;
  logic [7:0]  cfgOffset = '0, cfgEnCode = '0, cfgDisCode = '0;
  logic [4:0]  cfgStartBit = '0;
  logic [3:0]  cfgBits = '0;
  logic        busReq, busWr, busAck;
  logic [7:0]  busAddr;
  logic [31:0] busWdata, busRdata;

  always #(CYC / 2) clk = ~clk;

  devstate_seq u_dut (.*);

  // bus slave model
  logic [31:0] mem [0:255];
  logic        pokeEn = 1'b0, armLoad = 1'b0;
  logic [7:0]  pokeAddr = '0, armAddr = '0;
  logic [31:0] pokeData = '0, armVal = '0;
  int          armK = 0, armLeft, opCount, statReads;

  assign busRdata = mem[busAddr];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAck <= 1'b0; opCount <= 0; statReads <= 0; armLeft <= 0;
    end else begin
      if (pokeEn) mem[pokeAddr] <= pokeData;
      if (armLoad) armLeft <= armK;
      busAck <= busReq && !busAck;
      if (busReq && busAck) begin
        opCount <= opCount + 1;
        if (busWr) mem[busAddr] <= busWdata;
        else if (busAddr == armAddr && !armLoad) begin
          statReads <= statReads + 1;
          if (armLeft == 1) mem[armAddr] <= armVal;
          if (armLeft != 0) armLeft <= armLeft - 1;
        end
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench copy of the tables
  int cS[8], cC[8], cO[8], cE[8], cD[8], cB[8], cN[8];
  int sS[8], sC[8], sO[8], sE[8], sD[8], sB[8], sN[8];
  logic [31:0] expReg [0:15];

  task automatic loadEntry(input bit tbl, input int idx, input int st, input int cnt,
                           input int off, input int en, input int dis, input int sb, input int nb);
    @(negedge clk);
    cfgWe = 1'b1; cfgTable = tbl; cfgIdx = 3'(idx); cfgStartId = 5'(st);
    cfgCount = 6'(cnt); cfgOffset = 8'(off); cfgEnCode = 8'(en); cfgDisCode = 8'(dis);
    cfgStartBit = 5'(sb); cfgBits = 4'(nb);
    @(negedge clk);
    cfgWe = 1'b0;
    if (!tbl) begin cS[idx]=st; cC[idx]=cnt; cO[idx]=off; cE[idx]=en; cD[idx]=dis; cB[idx]=sb; cN[idx]=nb; end
    else      begin sS[idx]=st; sC[idx]=cnt; sO[idx]=off; sE[idx]=en; sD[idx]=dis; sB[idx]=sb; sN[idx]=nb; end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    pokeAddr = 8'(a); pokeData = d; pokeEn = 1'b1;
    @(negedge clk);
    pokeEn = 1'b0;
    if (a < 16) expReg[a] = d;
  endtask

  function automatic int findCtl(input int id);
    for (int i = 0; i < 8; i++) if (cC[i] != 0 && id >= cS[i] && id < cS[i] + cC[i]) return i;
    return -1;
  endfunction

  function automatic int findStat(input int id);
    for (int i = 0; i < 8; i++) if (sC[i] != 0 && id >= sS[i] && id < sS[i] + sC[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] putField(input logic [31:0] w, input int pos, input int nb, input int code);
    logic [31:0] ones = (32'd1 << nb) - 32'd1;
    return (w & ~(ones << pos)) | ((32'(code) & ones) << pos);
  endfunction

  task automatic runReq(input int id, input logic [1:0] st, input int k, input int lim);
    int ci, si, expErr, expReads, pos, code, thr, op0, rd0, waitCyc;
    bit busyOk;
    logic [31:0] pre, fin;
    logic [1:0] gotErr;
    ci = findCtl(id); si = findStat(id);
    expReads = 0; expErr = 0;
    if ((st != 2'b01 && st != 2'b10) || ci < 0) expErr = 1;          // R5, R1
    else if (st == 2'b10 && cD[ci] == 255) expErr = 3;               // R4
    else begin
      code = (st == 2'b01) ? cE[ci] : cD[ci];
      pos  = cB[ci] + cN[ci] * (id - cS[ci]);                         // R2
      expReg[cO[ci]] = putField(expReg[cO[ci]], pos, cN[ci], code);  // R3
    end
    armK = 0; armAddr = 8'hFF;
    if (expErr == 0 && si >= 0) begin
      code = (st == 2'b01) ? sE[si] : sD[si];
      pos  = sB[si] + sN[si] * (id - sS[si]);
      fin  = putField(mem[sO[si]], pos, sN[si], code);
      pre  = putField(fin, pos, sN[si], code ^ ((1 << sN[si]) - 1));
      poke(sO[si], (k == 0) ? fin : pre);
      armAddr = 8'(sO[si]); armVal = fin; armK = k;
      thr = (lim < 1) ? 1 : lim;
      if (k >= thr) begin expErr = 2; expReads = thr; end             // R8
      else expReads = k + 1;                                          // R6
    end
    @(negedge clk); armLoad = 1'b1; pollLimit = 16'(lim);
    @(negedge clk); armLoad = 1'b0;
    op0 = opCount; rd0 = statReads;
    reqValid = 1'b1; reqId = 5'(id); reqState = st;
    @(negedge clk);
    reqValid = 1'b0;
    busyOk = !reqReady;
    waitCyc = 0;
    while (!done && waitCyc < 2000) begin
      @(negedge clk);
      if (!done && reqReady) busyOk = 1'b0;
      waitCyc++;
    end
    gotErr = errCode;
    check("R9 done arrives", done, 32'(done), 1);
    check("R9 ready low while busy", busyOk, 32'(busyOk), 1);
    check($sformatf("R4/R5/R6/R8 result id=%0d st=%0d", id, st), gotErr == 2'(expErr), 32'(gotErr), 32'(expErr));
    @(negedge clk);
    check("R9 done one cycle, ready back", !done && reqReady, {30'd0, done, reqReady}, 32'd1);
    check($sformatf("R5/R7 bus op count id=%0d", id), (opCount - op0) == ((expErr == 1 || expErr == 3) ? 0 : 2 + expReads),
          32'(opCount - op0), 32'((expErr == 1 || expErr == 3) ? 0 : 2 + expReads));
    check($sformatf("R6/R8 status reads id=%0d", id), (statReads - rd0) == expReads, 32'(statReads - rd0), 32'(expReads));
    for (int r = 1; r <= 4; r++)
      check($sformatf("R3 reg%0d after id=%0d st=%0d", r, id, st), mem[r] == expReg[r], mem[r], expReg[r]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin cC[i] = 0; sC[i] = 0; end
    for (int i = 0; i < 16; i++) expReg[i] = '0;
    repeat (3) @(negedge clk);
    check("R11 ready in reset", reqReady == 1'b1, 32'(reqReady), 1);
    check("R11 done in reset", done == 1'b0, 32'(done), 0);
    check("R11 busReq in reset", busReq == 1'b0, 32'(busReq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 ready after reset", reqReady == 1'b1 && !busReq && !done, {29'd0, reqReady, busReq, done}, 32'd4);

    poke(1, 32'hA5A5_5A5A); poke(2, 32'h1234_5678); poke(3, 32'hF0F0_0F0F);
    poke(4, 32'hDEAD_BEEF); poke(10, 32'h0000_FF00); poke(11, 32'h0);

    // R1: empty tables after reset, request rejected
    runReq(0, 2'b01, 0, 4);

    loadEntry(0, 0, 0, 8, 1, 1, 0, 0, 1);
    loadEntry(0, 1, 8, 4, 2, 3, 1, 4, 2);
    loadEntry(0, 2, 12, 4, 2, 5, 255, 16, 4);
    loadEntry(0, 3, 16, 8, 3, 2, 1, 8, 3);
    loadEntry(0, 5, 0, 2, 4, 7, 7, 0, 3);   // R1 shadowed by entry 0
    loadEntry(1, 0, 8, 8, 10, 1, 0, 0, 1);
    loadEntry(1, 2, 20, 2, 11, 3, 0, 4, 2);

    for (int id = 0; id < 32; id++) begin
      runReq(id, 2'b01, id % 3, 4);
      runReq(id, 2'b10, (id + 1) % 3, 4);
    end

    runReq(3, 2'b00, 0, 4);  // R5 invalid state
    runReq(3, 2'b11, 0, 4);  // R5 invalid state

    // R8 timeout boundaries on a status-backed device
    runReq(9, 2'b01, 5, 3);
    runReq(9, 2'b10, 5, 0);
    runReq(9, 2'b01, 3, 3);
    runReq(9, 2'b10, 2, 3);
    runReq(21, 2'b01, 1, 1);
    runReq(21, 2'b10, 0, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule